// File: doc/BRIEF.md
# Mode-Banked Integer Register File with Exception Entry

This block holds the sixteen architectural integer registers of a load/store RISC core. Some registers have private copies that belong to a privilege mode. The block also holds the current status word and one saved status word for each exception mode. Every register access is steered to the physical copy that the current mode owns. Register 15 is the program counter. It is an ordinary shared register here, and its value is the same in every mode.

Seven exception request lines feed a priority picker. The picker takes account of the interrupt masks in the status word. When a request wins, the block enters the exception in a single clock edge. It switches the mode, saves the old status word into the new mode's saved slot, and raises the interrupt masks. It also writes the supplied return address into the new mode's link register (R14) and presents the handler address for one cycle. Fetch, decode and execution stay outside the block, and so does the decision of when a fault becomes visible.

Top module: `bankreg_core`

## Requirements
- R1: A synchronous reset gives status 0xC2, which is mode supervisor with the I mask (bit 7) and the F mask (bit 6) set. Reset also clears every saved status word and holds `exc_taken` low.
- R2: Both read ports are registered with one cycle of latency. A read returns the register contents as they stood before any write at the same edge.
- R3: The mode field is status bits [2:0], coded as user 0, system 1, supervisor 2, abort 3, undefined 4, IRQ 5 and FIQ 6. User and system modes see the same sixteen registers. R0 to R7 and R15 are shared by every mode.
- R4: FIQ mode has its own copies of R8 to R14. Writing one of them leaves the values seen in user and system modes unchanged.
- R5: Supervisor, abort, undefined and IRQ modes each have their own R13 and R14. They share R8 to R12 with user mode.
- R6: In any mode except user, a status write replaces the whole word. It is ignored entirely if its mode field is 7. In user mode only the condition bits [5:3] are written, so the mode and the masks cannot change.
- R7: `saved_status` shows the saved word of the current mode. In user and system modes it shows 0.
- R8: Priority runs, from highest to lowest: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt. IRQ is ignored while the I mask is set, and FIQ is ignored while the F mask is set.
- R9: Exception entry takes effect at the edge that samples the request. After that edge the mode is the target mode and the I mask is set. The F mask is set for FIQ and reset and is otherwise kept. The condition bits are kept. The target mode's saved word holds the previous status, its R14 holds `exc_ret_addr`, and `exc_taken` is high for that one cycle.
- R10: The target modes and handler addresses (`VEC_BASE` plus an offset) are: reset goes to supervisor at 0x00, undefined goes to undefined at 0x04, software interrupt goes to supervisor at 0x08, prefetch abort goes to abort at 0x0C, data abort goes to abort at 0x10, IRQ goes to IRQ at 0x18, and FIQ goes to FIQ at 0x1C.
- R11: A register write at the entry edge goes to the bank of the old mode. When it hits the same storage as the link write, the link write wins. A status write at the entry edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_b_idx | input | 4 | Read port B register number |
| rd_a_data | output | DATA_W | Read port A data, one cycle later |
| rd_b_data | output | DATA_W | Read port B data, one cycle later |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | DATA_W | Register write data |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 8 | Status word write data |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| exc_ret_addr | input | DATA_W | Return address written to the link register on entry |
| status | output | 8 | Current status word |
| saved_status | output | 8 | Saved status word of the current mode |
| exc_taken | output | 1 | One-cycle entry pulse |
| exc_vector | output | DATA_W | Handler address of the last entry |

## Verification
The bench builds the block with `DATA_W` = 32 and `VEC_BASE` = 0xFFFF0000. A nonzero base shows that each handler address is the base plus its offset and not the bare offset. The directed scenarios leave a distinct marker in every bank of R8, R12, R13 and R14, then switch modes and read the markers back. That exposes any wrong mapping from register number to physical storage. The remaining scenarios drive several requests together, fire requests while the masks block them, and line up register writes and status writes with an entry edge to exercise the ordering rules.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int STAT_W       = 8;
  localparam int IBIT         = 7;
  localparam int FBIT         = 6;
  localparam int NUM_ARCH     = 16;
  localparam int FIQ_BASE     = NUM_ARCH;          // 7 private FIQ copies of R8..R14
  localparam int FIQ_COUNT    = 7;
  localparam int PRIV_BASE    = FIQ_BASE + FIQ_COUNT;
  localparam int PRIV_MODES   = 4;                 // svc, abt, und, irq
  localparam int PHYS_ENTRIES = PRIV_BASE + 2 * PRIV_MODES;
  localparam int PHYS_W       = $clog2(PHYS_ENTRIES);
  localparam int NUM_EXC      = 7;
  localparam int KIND_W       = 3;
  localparam int SAVED_SLOTS  = 5;

  localparam logic [2:0] MODE_USR = 3'd0;
  localparam logic [2:0] MODE_SYS = 3'd1;
  localparam logic [2:0] MODE_SVC = 3'd2;
  localparam logic [2:0] MODE_ABT = 3'd3;
  localparam logic [2:0] MODE_UND = 3'd4;
  localparam logic [2:0] MODE_IRQ = 3'd5;
  localparam logic [2:0] MODE_FIQ = 3'd6;
  localparam logic [2:0] MODE_BAD = 3'd7;

  localparam logic [STAT_W-1:0] STAT_RESET = 8'hC2;

  // Request index equals priority rank (0 is highest).
  localparam logic [KIND_W-1:0] EXC_RST  = 3'd0;
  localparam logic [KIND_W-1:0] EXC_DABT = 3'd1;
  localparam logic [KIND_W-1:0] EXC_FIQ  = 3'd2;
  localparam logic [KIND_W-1:0] EXC_IRQ  = 3'd3;
  localparam logic [KIND_W-1:0] EXC_PABT = 3'd4;
  localparam logic [KIND_W-1:0] EXC_UND  = 3'd5;
  localparam logic [KIND_W-1:0] EXC_SWI  = 3'd6;

  function automatic logic has_saved(input logic [2:0] m);
    return (m >= MODE_SVC) && (m <= MODE_FIQ);
  endfunction

  function automatic logic [2:0] saved_slot(input logic [2:0] m);
    case (m)
      MODE_SVC: return 3'd0;
      MODE_ABT: return 3'd1;
      MODE_UND: return 3'd2;
      MODE_IRQ: return 3'd3;
      MODE_FIQ: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] phys_idx(input logic [2:0] m, input logic [3:0] r);
    logic [PHYS_W-1:0] res;
    res = PHYS_W'(r);
    if (m == MODE_FIQ && r >= 4'd8 && r <= 4'd14)
      res = PHYS_W'(FIQ_BASE) + PHYS_W'(r - 4'd8);
    else if ((r == 4'd13 || r == 4'd14) && m >= MODE_SVC && m <= MODE_IRQ)
      res = PHYS_W'(PRIV_BASE) + PHYS_W'({saved_slot(m), 1'b0}) + PHYS_W'(r == 4'd14);
    return res;
  endfunction

  function automatic logic [2:0] target_mode(input logic [KIND_W-1:0] k);
    case (k)
      EXC_RST:  return MODE_SVC;
      EXC_DABT: return MODE_ABT;
      EXC_FIQ:  return MODE_FIQ;
      EXC_IRQ:  return MODE_IRQ;
      EXC_PABT: return MODE_ABT;
      EXC_UND:  return MODE_UND;
      default:  return MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vec_off(input logic [KIND_W-1:0] k);
    case (k)
      EXC_RST:  return 8'h00;
      EXC_DABT: return 8'h10;
      EXC_FIQ:  return 8'h1C;
      EXC_IRQ:  return 8'h18;
      EXC_PABT: return 8'h0C;
      EXC_UND:  return 8'h04;
      default:  return 8'h08;
    endcase
  endfunction

endpackage

// File: rtl/bankreg_arbiter.sv
module bankreg_arbiter
  import bankreg_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic [N-1:0]      req,
  input  logic              i_mask,
  input  logic              f_mask,
  output logic              take,
  output logic [KIND_W-1:0] kind
);
  logic [N-1:0] eff;
  logic [N-1:0] grant;

  always_comb begin
    eff = req;
    eff[EXC_FIQ] = req[EXC_FIQ] & ~f_mask;
    eff[EXC_IRQ] = req[EXC_IRQ] & ~i_mask;
  end

  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign grant[i] = eff[i];
    end else begin : g_rest
      assign grant[i] = eff[i] & ~(|eff[i-1:0]);
    end
  end

  always_comb begin
    kind = '0;
    for (int j = 0; j < N; j++)
      if (grant[j]) kind = KIND_W'(j);
  end

  assign take = |eff;

  always_comb begin
    a_one_grant_r8: assert ($onehot0(grant));
  end
endmodule

// File: rtl/bankreg_storage.sv
module bankreg_storage #(
  parameter int DW    = 32,
  parameter int DEPTH = 31
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we0,
  input  logic [$clog2(DEPTH)-1:0] wa0,
  input  logic [DW-1:0]            wd0,
  input  logic                     we1,
  input  logic [$clog2(DEPTH)-1:0] wa1,
  input  logic [DW-1:0]            wd1,
  input  logic [$clog2(DEPTH)-1:0] ra_a,
  input  logic [$clog2(DEPTH)-1:0] ra_b,
  output logic [DW-1:0]            rd_a,
  output logic [DW-1:0]            rd_b
);
  logic [DW-1:0] mem [DEPTH];

  // Port 1 is assigned last, so it wins on a shared address.
  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      rd_a <= mem[ra_a];
      rd_b <= mem[ra_b];
    end
  end
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              take,
  input  logic [KIND_W-1:0] kind,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] saved_out
);
  logic [STAT_W-1:0] saved_q [SAVED_SLOTS];
  logic [2:0]        cur_mode;
  logic [2:0]        tgt_mode;
  logic              new_f;

  assign cur_mode = status_q[2:0];
  assign tgt_mode = target_mode(kind);
  assign new_f    = status_q[FBIT] | (kind == EXC_FIQ) | (kind == EXC_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= STAT_RESET;
      for (int s = 0; s < SAVED_SLOTS; s++) saved_q[s] <= '0;
    end else if (take) begin
      saved_q[saved_slot(tgt_mode)] <= status_q;
      status_q <= {1'b1, new_f, status_q[5:3], tgt_mode};
    end else if (wr_en) begin
      if (cur_mode == MODE_USR)
        status_q[5:3] <= wr_data[5:3];
      else if (wr_data[2:0] != MODE_BAD)
        status_q <= wr_data;
    end
  end

  assign saved_out = has_saved(cur_mode) ? saved_q[saved_slot(cur_mode)] : '0;

  p_entry_sets_i_r9: assert property (@(posedge clk) disable iff (rst)
    take |=> status_q[IBIT]);
  p_fast_entry_sets_f_r9: assert property (@(posedge clk) disable iff (rst)
    (take && (kind == EXC_FIQ || kind == EXC_RST)) |=> status_q[FBIT]);
  p_saved_copy_r9: assert property (@(posedge clk) disable iff (rst)
    take |=> saved_out == $past(status_q));
  p_user_keeps_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_USR && !take) |=> cur_mode == MODE_USR);
endmodule

// File: rtl/bankreg_core.sv
module bankreg_core
  import bankreg_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_wr_en,
  input  logic [7:0]        stat_wr_data,
  input  logic              req_reset,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic [DATA_W-1:0] exc_ret_addr,
  output logic [7:0]        status,
  output logic [7:0]        saved_status,
  output logic              exc_taken,
  output logic [DATA_W-1:0] exc_vector
);
  localparam logic [DATA_W-1:0] BASE = DATA_W'(VEC_BASE);

  logic [NUM_EXC-1:0] req_vec;
  logic               take;
  logic [KIND_W-1:0]  kind;
  logic [2:0]         cur_mode;
  logic [PHYS_W-1:0]  pa_w, pa_link, pa_ra, pa_rb;

  assign req_vec  = {req_swi, req_undef, req_pabt, req_irq, req_fiq, req_dabt, req_reset};
  assign cur_mode = status[2:0];
  assign pa_w     = phys_idx(cur_mode, wr_idx);
  assign pa_link  = phys_idx(target_mode(kind), 4'd14);
  assign pa_ra    = phys_idx(cur_mode, rd_a_idx);
  assign pa_rb    = phys_idx(cur_mode, rd_b_idx);

  bankreg_arbiter #(.N(NUM_EXC)) u_arb (
    .req    (req_vec),
    .i_mask (status[IBIT]),
    .f_mask (status[FBIT]),
    .take   (take),
    .kind   (kind)
  );

  bankreg_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (stat_wr_en),
    .wr_data   (stat_wr_data),
    .take      (take),
    .kind      (kind),
    .status_q  (status),
    .saved_out (saved_status)
  );

  bankreg_storage #(.DW(DATA_W), .DEPTH(PHYS_ENTRIES)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .we0  (wr_en),
    .wa0  (pa_w),
    .wd0  (wr_data),
    .we1  (take),
    .wa1  (pa_link),
    .wd1  (exc_ret_addr),
    .ra_a (pa_ra),
    .ra_b (pa_rb),
    .rd_a (rd_a_data),
    .rd_b (rd_b_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_taken  <= 1'b0;
      exc_vector <= '0;
    end else begin
      exc_taken <= take;
      if (take) exc_vector <= BASE + DATA_W'(vec_off(kind));
    end
  end

  p_entry_has_request_r8: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> $past(|req_vec));
  p_irq_vector_mode_r10: assert property (@(posedge clk) disable iff (rst)
    (exc_taken && exc_vector == BASE + DATA_W'(8'h18)) |-> cur_mode == MODE_IRQ);
  p_fiq_vector_mode_r10: assert property (@(posedge clk) disable iff (rst)
    (exc_taken && exc_vector == BASE + DATA_W'(8'h1C)) |-> cur_mode == MODE_FIQ);
  p_quiet_saved_r7: assert property (@(posedge clk) disable iff (rst)
    (cur_mode == MODE_USR || cur_mode == MODE_SYS) |-> saved_status == 8'h00);
endmodule

// File: tb/bankreg_core_tb.sv
module bankreg_core_tb;
  localparam logic [31:0] VB = 32'hFFFF_0000;
  localparam logic [6:0] B_RST = 7'h01, B_DABT = 7'h02, B_FIQ = 7'h04, B_IRQ = 7'h08,
                         B_PABT = 7'h10, B_UND = 7'h20, B_SWI = 7'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ra = '0, rb = '0, widx = '0;
  logic [31:0] wdat = '0, ret = '0;
  logic wen = 1'b0, sen = 1'b0;
  logic [7:0] sdat = '0;
  logic [6:0] breq = '0;
  logic [31:0] rda, rdb, vec;
  logic [7:0] stat, svd;
  logic tk;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bankreg_core #(.DATA_W(32), .VEC_BASE(VB)) u_dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(ra), .rd_b_idx(rb), .rd_a_data(rda), .rd_b_data(rdb),
    .wr_en(wen), .wr_idx(widx), .wr_data(wdat),
    .stat_wr_en(sen), .stat_wr_data(sdat),
    .req_reset(breq[0]), .req_undef(breq[5]), .req_swi(breq[6]), .req_pabt(breq[4]),
    .req_dabt(breq[1]), .req_irq(breq[3]), .req_fiq(breq[2]),
    .exc_ret_addr(ret), .status(stat), .saved_status(svd),
    .exc_taken(tk), .exc_vector(vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wreg(input logic [3:0] i, input logic [31:0] d);
    wen = 1'b1; widx = i; wdat = d; cyc(); wen = 1'b0;
  endtask
  task automatic wstat(input logic [7:0] s);
    sen = 1'b1; sdat = s; cyc(); sen = 1'b0;
  endtask
  task automatic rreg(input logic [3:0] i, output logic [31:0] d);
    ra = i; cyc(); d = rda;
  endtask
  task automatic fire(input logic [6:0] r, input logic [31:0] a);
    breq = r; ret = a; cyc(); breq = '0;
  endtask
  task automatic entry(input string tag, input logic [31:0] v, input logic [7:0] s, input logic [7:0] sv);
    chk({tag, " taken"}, {31'b0, tk}, 32'd1);
    chk({tag, " vector"}, vec, v);
    chk({tag, " status"}, {24'b0, stat}, {24'b0, s});
    chk({tag, " saved"}, {24'b0, svd}, {24'b0, sv});
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) cyc(); rst = 1'b0; cyc();
    chk("R1 status", {24'b0, stat}, 32'hC2);
    chk("R1 taken", {31'b0, tk}, 32'd0);
    chk("R1 saved", {24'b0, svd}, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] d;
    wreg(4'd0, 32'h1111_0000);
    wreg(4'd15, 32'h0000_F00D);
    ra = 4'd0; rb = 4'd15;
    wen = 1'b1; widx = 4'd0; wdat = 32'h2222_0000; cyc(); wen = 1'b0;
    chk("R2 read before same-edge write", rda, 32'h1111_0000);
    chk("R2 port B", rdb, 32'h0000_F00D);
    cyc();
    chk("R2 read after write", rda, 32'h2222_0000);
    rreg(4'd0, d);
    chk("R3 R0 shared", d, 32'h2222_0000);
  endtask

  task automatic t_banks();
    logic [31:0] d;
    wstat(8'h01);
    chk("R6 privileged write", {24'b0, stat}, 32'h01);
    wreg(4'd13, 32'hA13); wreg(4'd14, 32'hA14); wreg(4'd12, 32'hA12); wreg(4'd8, 32'hA08);
    wstat(8'h05);
    wreg(4'd13, 32'hB13);
    rreg(4'd12, d); chk("R5 R12 shared in IRQ", d, 32'hA12);
    rreg(4'd13, d); chk("R5 IRQ own R13", d, 32'hB13);
    wstat(8'h01);
    rreg(4'd13, d); chk("R5 system R13 kept", d, 32'hA13);
    wstat(8'h06);
    wreg(4'd8, 32'hC08); wreg(4'd7, 32'h777);
    rreg(4'd8, d); chk("R4 FIQ R8", d, 32'hC08);
    rreg(4'd15, d); chk("R3 R15 shared in FIQ", d, 32'h0000_F00D);
    wstat(8'h01);
    rreg(4'd8, d); chk("R4 system R8 kept", d, 32'hA08);
    rreg(4'd7, d); chk("R3 R7 shared", d, 32'h777);
    wstat(8'h00);
    rreg(4'd13, d); chk("R3 user sees system R13", d, 32'hA13);
    chk("R7 user saved zero", {24'b0, svd}, 32'h0);
  endtask

  task automatic t_user_status();
    logic [31:0] d;
    wstat(8'hFA);
    chk("R6 user only condition bits", {24'b0, stat}, 32'h38);
    fire(B_SWI, 32'h0000_0050);
    entry("R10 swi", VB + 32'h08, 8'hBA, 8'h38);
    rreg(4'd14, d); chk("R9 svc link", d, 32'h0000_0050);
    chk("R9 pulse ends", {31'b0, tk}, 32'd0);
    wstat(8'h07);
    chk("R6 mode 7 ignored", {24'b0, stat}, 32'hBA);
    wstat(8'h01);
    chk("R7 system saved zero", {24'b0, svd}, 32'h0);
  endtask

  task automatic t_irq_fiq();
    logic [31:0] d;
    fire(B_IRQ, 32'h100);
    entry("R9 irq", VB + 32'h18, 8'h85, 8'h01);
    rreg(4'd14, d); chk("R9 irq link", d, 32'h100);
    fire(B_IRQ, 32'h111);
    chk("R8 irq masked", {31'b0, tk}, 32'd0);
    chk("R8 status held", {24'b0, stat}, 32'h85);
    fire(B_FIQ, 32'h200);
    entry("R8 fiq preempts irq", VB + 32'h1C, 8'hC6, 8'h85);
    rreg(4'd14, d); chk("R4 fiq link", d, 32'h200);
    fire(B_FIQ | B_IRQ, 32'h222);
    chk("R8 fiq handler not interrupted", {31'b0, tk}, 32'd0);
    chk("R8 fiq status held", {24'b0, stat}, 32'hC6);
  endtask

  task automatic t_priority();
    wstat(8'h01);
    fire(B_DABT | B_FIQ | B_IRQ | B_PABT, 32'h300);
    entry("R8 dabt first", VB + 32'h10, 8'h83, 8'h01);
    wstat(8'h03);
    fire(B_FIQ | B_IRQ | B_PABT | B_UND | B_SWI, 32'h304);
    entry("R8 fiq over irq", VB + 32'h1C, 8'hC6, 8'h03);
    wstat(8'h01);
    fire(B_PABT | B_UND | B_SWI, 32'h308);
    entry("R10 pabt", VB + 32'h0C, 8'h83, 8'h01);
    wstat(8'h01);
    fire(B_UND | B_SWI, 32'h30C);
    entry("R10 undef over swi", VB + 32'h04, 8'h84, 8'h01);
    wstat(8'h01);
    fire(7'h7F, 32'h310);
    entry("R10 reset wins all", VB + 32'h00, 8'hC2, 8'h01);
  endtask

  task automatic t_same_edge();
    logic [31:0] d;
    wstat(8'h01);
    wen = 1'b1; widx = 4'd13; wdat = 32'hD13; breq = B_IRQ; ret = 32'h400;
    cyc(); wen = 1'b0; breq = '0;
    entry("R11 irq with write", VB + 32'h18, 8'h85, 8'h01);
    rreg(4'd13, d); chk("R11 irq R13 untouched", d, 32'hB13);
    rreg(4'd14, d); chk("R11 irq link", d, 32'h400);
    wstat(8'h01);
    rreg(4'd13, d); chk("R11 write in old bank", d, 32'hD13);
    wstat(8'h02);
    wen = 1'b1; widx = 4'd14; wdat = 32'hEEE; breq = B_SWI; ret = 32'h500;
    cyc(); wen = 1'b0; breq = '0;
    entry("R11 swi in svc", VB + 32'h08, 8'h82, 8'h02);
    rreg(4'd14, d); chk("R11 link wins", d, 32'h500);
    wstat(8'h01);
    sen = 1'b1; sdat = 8'h06; breq = B_IRQ; ret = 32'h600;
    cyc(); sen = 1'b0; breq = '0;
    entry("R11 status write dropped", VB + 32'h18, 8'h85, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R9 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    cyc();
    t_reset();
    t_read_timing();
    t_banks();
    t_user_status();
    t_irq_fiq();
    t_priority();
    t_same_edge();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule